// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side controller for a 12-bit, two-input serial ADC. The converter has no chip select. It has a conversion-start line instead. A rising edge on that line starts a conversion. The line must stay high for the conversion time. When it is lowered, the converter and the host exchange data in both directions at once over a shift clock. During that shift the host sends a 2-bit input-selection word, and the converter returns the finished 12-bit result.

The selection sent during one frame sets the converter's input for the *next* conversion, not for the result being read in that frame. The sequencer therefore keeps track of which selection each result was measured with, and it labels every result with that selection. No frame has gone out before the first result after reset, so the first result is marked as having an unknown selection.

Requests enter on a valid/ready stream. There is a single holding slot. While that slot is full, `req_ready` is low, and a request sent during a running frame waits in the slot until the frame ends. Results leave on a valid/ready stream. Once `res_valid` is high, the result, its label and its known flag stay high and unchanged until `res_ready` takes them. No new conversion starts while a result is waiting. The conversion time and the shift-clock half period are plain control inputs, counted in system clock cycles.

The two selection bits mean the following:
- Single-ended = 1 and odd = 0: input 0 is measured against ground.
- Single-ended = 1 and odd = 1: input 1 is measured against ground.
- Single-ended = 0 and odd = 0: input 0 is the positive input and input 1 the negative.
- Single-ended = 0 and odd = 1: the same pair with the polarity reversed.

Top module: `adc_conv_seq`

## Requirements
- R1: While reset is asserted and after its release, `adc_conv`, `adc_sck`, `adc_sdi` and `res_valid` are low and `req_ready` is high.
- R2: An accepted request raises `adc_conv` for exactly max(`conv_cycles`,1) system clock cycles before it is lowered.
- R3: `adc_sck` is low whenever `adc_conv` is high. Each frame gives exactly 12 rising `adc_sck` edges after `adc_conv` falls. Each high phase and each low phase between rising edges lasts max(`sck_half`,1) system clock cycles.
- R4: At the first rising `adc_sck` edge of a frame, `adc_sdi` carries `req_cfg[1]` (single-ended). At the second it carries `req_cfg[0]` (odd). At every later rising edge it is 0. `adc_sdi` is low while `adc_conv` is high.
- R5: `res_data` holds the 12 `adc_sdo` bits sampled at the rising `adc_sck` edges, most significant bit first. The level of `adc_sdo` while `adc_conv` is high has no effect.
- R6: `res_cfg` equals the `req_cfg` that was sent in the previous frame. `res_cfg_known` is 0 on the first result after reset and 1 on every later result.
- R7: The request holding slot has one entry. `req_ready` is low while the slot is full. A request accepted during a running frame starts the next `adc_conv` pulse after that frame ends, with no further request needed.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data`, `res_cfg` and `res_cfg_known` hold their values, and `adc_conv` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_cycles | input | CONV_W | Conversion hold time in clock cycles (0 acts as 1) |
| sck_half | input | DIV_W | Shift clock half period in clock cycles (0 acts as 1) |
| req_valid | input | 1 | Conversion request valid |
| req_ready | output | 1 | Holding slot free |
| req_cfg | input | 2 | Selection to send: [1] single-ended, [0] odd |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_data | output | RES_W | Converted value |
| res_cfg | output | 2 | Selection the value was measured with |
| res_cfg_known | output | 1 | Label is valid (0 on the first result) |
| adc_conv | output | 1 | Conversion-start line to the converter |
| adc_sck | output | 1 | Shift clock, idles low |
| adc_sdi | output | 1 | Serial data to the converter |
| adc_sdo | input | 1 | Serial data from the converter |

## Verification
The bound checker watches several properties on every cycle:
- the shift clock stays quiet while the conversion line is high;
- the data-in line stays quiet during that phase;
- the conversion pulse has its exact width;
- no frame delivers more than 12 rising edges;
- results stay stable while back-pressured;
- a finished frame never finds a waiting result;
- the known flag is correct on the first result and on every later one.

Some behaviours only the directed scenarios can show. These include:
- the values carried by the selection bits;
- the one-frame lag between a selection and the result it labels;
- the data assembly from the responder;
- that `adc_sdo` is ignored during conversion;
- that a request held in the slot starts on its own once the running frame ends.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic single;
    logic odd;
  } sel_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CONV,
    SEQ_SHIFT
  } seq_state_t;
endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // a half period of zero behaves as one cycle
  assign lim  = (half == '0) ? '0 : half - 1'b1;
  assign tick = run && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || cnt_q >= lim) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
  parameter int RES_W = 12,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel_bits,
  input  logic             tick,
  input  logic             sdo,
  output logic             active,
  output logic             sck,
  output logic             sdi,
  output logic             done,
  output logic [RES_W-1:0] data
);
  localparam int CNT_W = $clog2(RES_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RES_W);

  logic             active_q;
  logic             sck_q;
  logic             sdi_q;
  logic             done_q;
  logic [CNT_W-1:0] bits_q;
  logic [SEL_W-1:0] tx_q;
  logic [RES_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      sdi_q    <= 1'b0;
      done_q   <= 1'b0;
      bits_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        sck_q    <= 1'b0;
        sdi_q    <= sel_bits[SEL_W-1];
        tx_q     <= {sel_bits[SEL_W-2:0], 1'b0};
        bits_q   <= '0;
        rx_q     <= '0;
      end else if (active_q && tick) begin
        if (!sck_q) begin
          if (bits_q == LAST) begin
            // trailing low half period, then the frame closes
            active_q <= 1'b0;
            done_q   <= 1'b1;
            sdi_q    <= 1'b0;
          end else begin
            sck_q  <= 1'b1;
            rx_q   <= {rx_q[RES_W-2:0], sdo};
            bits_q <= bits_q + 1'b1;
          end
        end else begin
          // falling edge: present the next selection bit, zeros afterwards
          sck_q <= 1'b0;
          sdi_q <= tx_q[SEL_W-1];
          tx_q  <= {tx_q[SEL_W-2:0], 1'b0};
        end
      end
    end
  end

  assign active = active_q;
  assign sck    = sck_q;
  assign sdi    = sdi_q;
  assign done   = done_q;
  assign data   = rx_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  output logic              req_ready,
  input  logic [CONV_W-1:0] conv_cycles,
  input  logic              res_busy,
  input  logic              shift_done,
  output logic              conv,
  output logic              shift_start,
  output logic [SEL_W-1:0]  frame_sel
);
  seq_state_t        state_q;
  logic              pend_q;
  logic [SEL_W-1:0]  pend_sel_q;
  logic [SEL_W-1:0]  cur_sel_q;
  logic [CONV_W-1:0] cnt_q;
  logic              conv_q;
  logic              start_q;

  assign req_ready = !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      pend_q     <= 1'b0;
      pend_sel_q <= '0;
      cur_sel_q  <= '0;
      cnt_q      <= '0;
      conv_q     <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (req_valid && !pend_q) begin
        pend_q     <= 1'b1;
        pend_sel_q <= req_sel;
      end
      unique case (state_q)
        SEQ_IDLE: begin
          if (pend_q && !res_busy) begin
            conv_q    <= 1'b1;
            cnt_q     <= CONV_W'(1);
            cur_sel_q <= pend_sel_q;
            pend_q    <= 1'b0;
            state_q   <= SEQ_CONV;
          end
        end
        SEQ_CONV: begin
          if (cnt_q >= conv_cycles) begin
            conv_q  <= 1'b0;
            start_q <= 1'b1;
            state_q <= SEQ_SHIFT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_SHIFT: begin
          if (shift_done) begin
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign conv        = conv_q;
  assign shift_start = start_q;
  assign frame_sel   = cur_sel_q;
endmodule

// File: rtl/adc_seq_tagger.sv
module adc_seq_tagger #(
  parameter int RES_W = 12,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [RES_W-1:0] frame_data,
  input  logic [SEL_W-1:0] frame_sel,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic [SEL_W-1:0] res_cfg,
  output logic             res_cfg_known
);
  logic [SEL_W-1:0] prev_sel_q;
  logic             prev_known_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sel_q    <= '0;
      prev_known_q  <= 1'b0;
      res_valid     <= 1'b0;
      res_data      <= '0;
      res_cfg       <= '0;
      res_cfg_known <= 1'b0;
    end else if (frame_done) begin
      // the value read now was converted with the selection of the prior frame
      res_valid     <= 1'b1;
      res_data      <= frame_data;
      res_cfg       <= prev_sel_q;
      res_cfg_known <= prev_known_q;
      prev_sel_q    <= frame_sel;
      prev_known_q  <= 1'b1;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int CONV_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CONV_W-1:0] conv_cycles,
  input  logic [DIV_W-1:0]  sck_half,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cfg,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_data,
  output logic [1:0]        res_cfg,
  output logic              res_cfg_known,
  output logic              adc_conv,
  output logic              adc_sck,
  output logic              adc_sdi,
  input  logic              adc_sdo
);
  logic             shift_start;
  logic             shift_done;
  logic             shift_active;
  logic             div_tick;
  logic [SEL_W-1:0] frame_sel;
  logic [RES_W-1:0] frame_data;

  adc_seq_ctrl #(.CONV_W(CONV_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_sel     (req_cfg),
    .req_ready   (req_ready),
    .conv_cycles (conv_cycles),
    .res_busy    (res_valid),
    .shift_done  (shift_done),
    .conv        (adc_conv),
    .shift_start (shift_start),
    .frame_sel   (frame_sel)
  );

  adc_seq_clkdiv #(.DIV_W(DIV_W)) i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (shift_active),
    .half  (sck_half),
    .tick  (div_tick)
  );

  adc_seq_shifter #(.RES_W(RES_W), .SEL_W(SEL_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (shift_start),
    .sel_bits (frame_sel),
    .tick     (div_tick),
    .sdo      (adc_sdo),
    .active   (shift_active),
    .sck      (adc_sck),
    .sdi      (adc_sdi),
    .done     (shift_done),
    .data     (frame_data)
  );

  adc_seq_tagger #(.RES_W(RES_W), .SEL_W(SEL_W)) i_tag (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_done    (shift_done),
    .frame_data    (frame_data),
    .frame_sel     (frame_sel),
    .res_ready     (res_ready),
    .res_valid     (res_valid),
    .res_data      (res_data),
    .res_cfg       (res_cfg),
    .res_cfg_known (res_cfg_known)
  );
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int RES_W  = 12,
  parameter int CONV_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CONV_W-1:0] conv_cycles,
  input logic              res_valid,
  input logic              res_ready,
  input logic [RES_W-1:0]  res_data,
  input logic [1:0]        res_cfg,
  input logic              res_cfg_known,
  input logic              adc_conv,
  input logic              adc_sck,
  input logic              adc_sdi,
  input logic              shift_done
);
  localparam int RC_W = $clog2(RES_W + 2);

  logic [CONV_W:0] conv_run_q;
  logic [CONV_W:0] conv_exp;
  logic [RC_W-1:0] rise_q;
  logic            sck_d_q;
  logic            got_q;

  assign conv_exp = (conv_cycles == '0) ? (CONV_W+1)'(1) : {1'b0, conv_cycles};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_run_q <= '0;
      rise_q     <= '0;
      sck_d_q    <= 1'b0;
      got_q      <= 1'b0;
    end else begin
      sck_d_q <= adc_sck;
      if (adc_conv) conv_run_q <= conv_run_q + 1'b1;
      else          conv_run_q <= '0;
      if (adc_conv)                rise_q <= '0;
      else if (adc_sck && !sck_d_q) rise_q <= rise_q + 1'b1;
      if (res_valid && res_ready) got_q <= 1'b1;
    end
  end

  // R3
  sck_quiet_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> !adc_sck);

  // R4
  sdi_quiet_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> !adc_sdi);

  // R2
  conv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv) |-> conv_run_q == conv_exp);

  // R3
  sck_count_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q <= RC_W'(RES_W));

  // R3
  sck_count_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> (rise_q == '0 || rise_q == RC_W'(RES_W)));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_cfg)
                                && $stable(res_cfg_known));

  // R8
  no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> !res_valid);

  // R8
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |-> !res_valid);

  // R6
  first_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !got_q |-> !res_cfg_known);

  // R6
  later_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && got_q |-> res_cfg_known);
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_W(RES_W), .CONV_W(CONV_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .conv_cycles   (conv_cycles),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_data      (res_data),
  .res_cfg       (res_cfg),
  .res_cfg_known (res_cfg_known),
  .adc_conv      (adc_conv),
  .adc_sck       (adc_sck),
  .adc_sdi       (adc_sdi),
  .shift_done    (shift_done)
);

// File: tb/test_adc_conv_seq.sv
`timescale 1ns/1ps
module test_adc_conv_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] conv_cycles = 16'd5;
  logic [7:0]  sck_half = 8'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cfg = 2'b00;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [11:0] res_data;
  logic [1:0]  res_cfg;
  logic        res_cfg_known;
  logic        adc_conv, adc_sck, adc_sdi;
  logic        adc_sdo = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // responder state
  logic [1:0]  mux = 2'b10;
  logic [11:0] samp = '0;
  logic [11:0] sh = '0;
  logic        s_bit = 1'b0;
  logic        conv_p = 1'b0, sck_p = 1'b0;
  int conv_idx = 0, rise_n = 0, bitpos = 0;
  int conv_run = 0, last_conv_w = 0, hi_run = 0, lo_run = 0;
  int hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
  int extra_sdi = 0, sdi_conv_bad = 0;
  logic [1:0] cfg_log [0:31];
  int         rise_log [0:31];

  // bench bookkeeping
  logic [1:0] req_log [0:31];
  int req_wr = 0, res_rd = 0;

  always #4 clk = ~clk;

  adc_conv_seq i_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .conv_cycles(conv_cycles), .sck_half(sck_half),
    .req_valid(req_valid), .req_ready(req_ready), .req_cfg(req_cfg),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_cfg(res_cfg), .res_cfg_known(res_cfg_known), .adc_conv(adc_conv),
    .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo)
  );

  function automatic logic [11:0] model(input logic [1:0] m, input int k);
    logic [11:0] v;
    v = 12'(k * 293 + 61);
    return {m, v[9:0]} ^ 12'h3C6;
  endfunction

  // behavioural converter, evaluated away from the active edge
  always @(negedge clk) begin
    if (adc_conv && !conv_p) begin
      samp = model(mux, conv_idx);
      conv_idx++;
      rise_n = 0;
      adc_sdo = 1'b1;
      hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
      hi_run = 0; lo_run = 0;
    end
    if (!adc_conv && conv_p) begin
      sh = samp;
      adc_sdo = sh[11];
      bitpos = 1;
      last_conv_w = conv_run;
      conv_run = 0;
    end
    if (adc_conv) conv_run++;
    if (adc_conv && adc_sdi) sdi_conv_bad++;
    if (adc_sck && !sck_p) begin
      if (rise_n > 0) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
      end
      lo_run = 0;
      rise_n++;
      if (rise_n == 1) s_bit = adc_sdi;
      else if (rise_n == 2) begin
        mux = {s_bit, adc_sdi};
        cfg_log[conv_idx-1] = {s_bit, adc_sdi};
      end else if (adc_sdi) extra_sdi++;
      rise_log[conv_idx-1] = rise_n;
    end
    if (!adc_sck && sck_p) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
      if (!adc_conv) begin
        if (bitpos < 12) adc_sdo = sh[11-bitpos];
        else adc_sdo = 1'b0;
        bitpos++;
      end
    end
    if (adc_sck) hi_run++;
    else lo_run++;
    conv_p = adc_conv;
    sck_p = adc_sck;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_req(input logic [1:0] cfg);
    req_valid = 1'b1;
    req_cfg = cfg;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_log[req_wr] = cfg;
    req_wr++;
  endtask

  task automatic check_next_result(input int exp_conv, input int exp_half);
    logic [1:0] used;
    while (!res_valid) @(negedge clk);
    used = (res_rd == 0) ? 2'b10 : req_log[res_rd-1];
    chk("R5", "result data (sdo high during conversion ignored)", res_data, model(used, res_rd));
    chk("R6", "label known flag", res_cfg_known, (res_rd != 0) ? 1 : 0);
    if (res_rd != 0) chk("R6", "label selection", res_cfg, req_log[res_rd-1]);
    chk("R4", "selection bits seen by converter", cfg_log[res_rd], req_log[res_rd]);
    chk("R4", "extra sdi ones", extra_sdi, 0);
    chk("R3", "rising sck edges in frame", rise_log[res_rd], 12);
    chk("R2", "conv high cycles", last_conv_w, exp_conv);
    chk("R3", "sck high min", hi_min, exp_half);
    chk("R3", "sck high max", hi_max, exp_half);
    chk("R3", "sck low min", lo_min, exp_half);
    chk("R3", "sck low max", lo_max, exp_half);
    res_rd++;
    if (res_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "conv in reset", adc_conv, 0);
    chk("R1", "sck in reset", adc_sck, 0);
    chk("R1", "sdi in reset", adc_sdi, 0);
    chk("R1", "res_valid in reset", res_valid, 0);
    chk("R1", "req_ready in reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "conv after reset", adc_conv, 0);
    chk("R1", "req_ready after reset", req_ready, 1);
  endtask

  task automatic t_frame(input logic [1:0] cfg, input int convc, input int half);
    conv_cycles = 16'(convc);
    sck_half = 8'(half);
    send_req(cfg);
    check_next_result((convc == 0) ? 1 : convc, (half == 0) ? 1 : half);
    chk("R4", "sdi high during conversion", sdi_conv_bad, 0);
  endtask

  task automatic t_pending();
    int start_idx;
    conv_cycles = 16'd30;
    sck_half = 8'd2;
    start_idx = conv_idx;
    send_req(2'b01);
    while (!adc_conv) @(negedge clk);
    send_req(2'b10);
    chk("R7", "req_ready with slot full", req_ready, 0);
    check_next_result(30, 2);
    check_next_result(30, 2);
    chk("R7", "held request launched", conv_idx - start_idx, 2);
  endtask

  task automatic t_backpressure();
    int ci;
    logic [11:0] held;
    conv_cycles = 16'd3;
    sck_half = 8'd1;
    res_ready = 1'b0;
    send_req(2'b11);
    while (!res_valid) @(negedge clk);
    ci = conv_idx;
    held = res_data;
    send_req(2'b00);
    repeat (60) @(negedge clk);
    chk("R8", "res_valid held", res_valid, 1);
    chk("R8", "res_data held", res_data, held);
    chk("R8", "no conversion while result waits", conv_idx, ci);
    check_next_result(3, 1);
    res_ready = 1'b1;
    @(negedge clk);
    check_next_result(3, 1);
  endtask

  initial begin
    t_reset();
    t_frame(2'b10, 5, 2);
    t_frame(2'b11, 1, 1);
    t_frame(2'b00, 0, 0);
    t_frame(2'b01, 20, 3);
    t_pending();
    t_backpressure();
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", res_rd, req_wr);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule